// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a virtual address into a physical one through a small per-process segment table. The upper bits of the virtual address pick a table entry and the lower bits are an offset into that segment. Each entry holds a base address, a size, and a two-bit permission code. The offset is added to the entry's base. The access is refused if the offset runs past the segment's size, or if the entry does not grant the kind of access requested (load, store or instruction fetch).

Privileged software fills the table through a write port. On a context switch it saves the outgoing process's entries through a read port and reloads the incoming process's entries. A write attempted outside privileged mode leaves the table untouched and raises a one-cycle violation pulse. Each translation result is registered and appears one clock after its request. Bound and permission failures are reported on separate outputs.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is `req_vaddr[31:29]` and the offset is `req_vaddr[28:0]`, so there are 8 table entries.
- R2: When neither error is flagged, `rsp_paddr` equals the entry's base plus the zero-extended offset, modulo 2^32.
- R3: `rsp_bound_err` is high when the offset is greater than the entry's size field. An offset equal to the size is legal.
- R4: Access kinds are encoded 00 load, 01 store, 10 fetch, and 11 load. Permission codes are encoded 00 none, 01 read-only, 10 read/write, and 11 execute. A load is granted by 01 or 10, a store only by 10, and a fetch only by 11. `rsp_perm_err` is high when the access is not granted.
- R5: A request with `req_valid` high at a clock edge produces `rsp_valid` high with its result after that edge, for one cycle. With no request, `rsp_valid`, `rsp_paddr` and both error outputs are zero.
- R6: `rsp_paddr` is zero whenever either error output is high. Both errors may be high together.
- R7: With `tbl_wr_en` and `priv_mode` both high, the entry at `tbl_wr_idx` takes the written base, size and permission at the clock edge. A request in the same cycle is translated with the old contents, and requests from the next cycle on use the new ones.
- R8: With `tbl_wr_en` high and `priv_mode` low, the table does not change, and `wr_violation` is high for exactly the cycle after that edge. Otherwise `wr_violation` is low.
- R9: The read port returns, without delay, the base, size and permission of entry `tbl_rd_idx`. Reset clears every entry to base 0, size 0 and permission none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address: segment number and offset |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_bound_err | output | 1 | Offset beyond the segment size |
| rsp_perm_err | output | 1 | Access kind not granted |
| priv_mode | input | 1 | Privileged mode, which allows table writes |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 3 | Entry to write |
| tbl_wr_base | input | 32 | Base to write |
| tbl_wr_size | input | 29 | Size (largest legal offset) to write |
| tbl_wr_perm | input | 2 | Permission code to write |
| wr_violation | output | 1 | Pulse after a write attempted outside privileged mode |
| tbl_rd_idx | input | 3 | Entry to read for saving |
| tbl_rd_base | output | 32 | Base of the read entry |
| tbl_rd_size | output | 29 | Size of the read entry |
| tbl_rd_perm | output | 2 | Permission code of the read entry |

## Verification
Translation results and `wr_violation` are due one clock after the edge that captures the request or the write attempt. The table read port answers in the same cycle. The bench drives every stimulus on a falling edge and computes the expected result from its own table model as it stood at that moment. The model takes a privileged write only after the rising edge, which matches the rule for a write and a request in the same cycle. The bench then checks the registered outputs on the next falling edge, and probes the read port between edges after a short settle delay.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b10,
    PERM_EXEC = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_e;

  // Whether a permission code grants an access kind.
  function automatic logic perm_grants(input logic [1:0] perm, input logic [1:0] kind);
    logic ok;
    case (perm_e'(perm))
      PERM_RO:   ok = (acc_e'(kind) == ACC_LOAD) || (acc_e'(kind) == ACC_LOAD2);
      PERM_RW:   ok = (acc_e'(kind) != ACC_FETCH);
      PERM_EXEC: ok = (acc_e'(kind) == ACC_FETCH);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W  = 3,
  parameter int OFF_W  = 29,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_mode,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [OFF_W-1:0]  wr_size,
  input  logic [1:0]        wr_perm,
  output logic              wr_violation,
  input  logic [SEG_W-1:0]  lk_idx,
  output logic [BASE_W-1:0] lk_base,
  output logic [OFF_W-1:0]  lk_size,
  output logic [1:0]        lk_perm,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [OFF_W-1:0]  rd_size,
  output logic [1:0]        rd_perm
);
  localparam int ENTRIES = 1 << SEG_W;

  logic [BASE_W-1:0] base_q [ENTRIES];
  logic [OFF_W-1:0]  size_q [ENTRIES];
  logic [1:0]        perm_q [ENTRIES];

  logic wr_ok;
  logic viol_d, viol_q;

  assign wr_ok  = wr_en & priv_mode;
  assign viol_d = wr_en & ~priv_mode;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic ld;
    assign ld = wr_ok && (wr_idx == SEG_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[e] <= '0;
        size_q[e] <= '0;
        perm_q[e] <= 2'b00;
      end else if (ld) begin
        base_q[e] <= wr_base;
        size_q[e] <= wr_size;
        perm_q[e] <= wr_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign wr_violation = viol_q;

  assign lk_base = base_q[lk_idx];
  assign lk_size = size_q[lk_idx];
  assign lk_perm = perm_q[lk_idx];
  assign rd_base = base_q[rd_idx];
  assign rd_size = size_q[rd_idx];
  assign rd_perm = perm_q[rd_idx];

  AST_WRV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv_mode) |=> wr_violation) else $error("wrv pulse"); // R8

  AST_WRV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !priv_mode) |=> !wr_violation) else $error("wrv quiet"); // R8

  AST_TBL_HOLD_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && priv_mode) |=>
      (!$stable(rd_idx) || ($stable(rd_base) && $stable(rd_size) && $stable(rd_perm))))
    else $error("table changed without privileged write"); // R8

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W  = 29,
  parameter int BASE_W = 32
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        kind,
  input  logic [BASE_W-1:0] base,
  input  logic [OFF_W-1:0]  size,
  input  logic [1:0]        perm,
  output logic [BASE_W-1:0] paddr,
  output logic              bound_err,
  output logic              perm_err
);
  logic [BASE_W-1:0] sum;

  always_comb begin
    sum       = base + BASE_W'(offset);
    bound_err = (offset > size);
    perm_err  = !perm_grants(perm, kind);
    paddr     = (bound_err || perm_err) ? '0 : sum;
  end

  always_comb begin
    if (!bound_err && !perm_err)
      AST_SUM_PASSTHRU: assert (paddr - base == BASE_W'(offset)) else $error("sum"); // R2
  end

endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BASE_W-1:0] paddr_in,
  input  logic              berr_in,
  input  logic              perr_in,
  output logic              rsp_valid,
  output logic [BASE_W-1:0] rsp_paddr,
  output logic              rsp_bound_err,
  output logic              rsp_perm_err
);
  logic              vld_d, berr_d, perr_d;
  logic [BASE_W-1:0] pa_d;
  logic              vld_q, berr_q, perr_q;
  logic [BASE_W-1:0] pa_q;

  always_comb begin
    vld_d  = req_valid;
    pa_d   = req_valid ? paddr_in : '0;
    berr_d = req_valid & berr_in;
    perr_d = req_valid & perr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pa_q   <= '0;
      berr_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      pa_q   <= pa_d;
      berr_q <= berr_d;
      perr_q <= perr_d;
    end
  end

  assign rsp_valid     = vld_q;
  assign rsp_paddr     = pa_q;
  assign rsp_bound_err = berr_q;
  assign rsp_perm_err  = perr_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_paddr == '0 && !rsp_bound_err && !rsp_perm_err))
    else $error("idle outputs not zero"); // R5

  AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_bound_err || rsp_perm_err) |-> rsp_paddr == '0)
    else $error("address leaked on error"); // R6

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 3,
  parameter int OFF_W  = 29,
  parameter int BASE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [SEG_W+OFF_W-1:0] req_vaddr,
  input  logic [1:0]             req_kind,
  output logic                   rsp_valid,
  output logic [BASE_W-1:0]      rsp_paddr,
  output logic                   rsp_bound_err,
  output logic                   rsp_perm_err,
  input  logic                   priv_mode,
  input  logic                   tbl_wr_en,
  input  logic [SEG_W-1:0]       tbl_wr_idx,
  input  logic [BASE_W-1:0]      tbl_wr_base,
  input  logic [OFF_W-1:0]       tbl_wr_size,
  input  logic [1:0]             tbl_wr_perm,
  output logic                   wr_violation,
  input  logic [SEG_W-1:0]       tbl_rd_idx,
  output logic [BASE_W-1:0]      tbl_rd_base,
  output logic [OFF_W-1:0]       tbl_rd_size,
  output logic [1:0]             tbl_rd_perm
);
  localparam int VA_W = SEG_W + OFF_W;

  logic [SEG_W-1:0]  seg_no;
  logic [OFF_W-1:0]  seg_off;
  logic [BASE_W-1:0] lk_base;
  logic [OFF_W-1:0]  lk_size;
  logic [1:0]        lk_perm;
  logic [BASE_W-1:0] x_paddr;
  logic              x_berr, x_perr;

  assign seg_no  = req_vaddr[VA_W-1:OFF_W];
  assign seg_off = req_vaddr[OFF_W-1:0];

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .priv_mode    (priv_mode),
    .wr_en        (tbl_wr_en),
    .wr_idx       (tbl_wr_idx),
    .wr_base      (tbl_wr_base),
    .wr_size      (tbl_wr_size),
    .wr_perm      (tbl_wr_perm),
    .wr_violation (wr_violation),
    .lk_idx       (seg_no),
    .lk_base      (lk_base),
    .lk_size      (lk_size),
    .lk_perm      (lk_perm),
    .rd_idx       (tbl_rd_idx),
    .rd_base      (tbl_rd_base),
    .rd_size      (tbl_rd_size),
    .rd_perm      (tbl_rd_perm)
  );

  seg_check #(.OFF_W(OFF_W), .BASE_W(BASE_W)) u_check (
    .offset    (seg_off),
    .kind      (req_kind),
    .base      (lk_base),
    .size      (lk_size),
    .perm      (lk_perm),
    .paddr     (x_paddr),
    .bound_err (x_berr),
    .perm_err  (x_perr)
  );

  seg_rsp_reg #(.BASE_W(BASE_W)) u_rsp (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .paddr_in      (x_paddr),
    .berr_in       (x_berr),
    .perr_in       (x_perr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_bound_err (rsp_bound_err),
    .rsp_perm_err  (rsp_perm_err)
  );

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid) else $error("response missing"); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid) else $error("spurious response"); // R5

  AST_BOUND_OK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_bound_err == ($past(seg_off) > $past(lk_size))))
    else $error("bound check mismatch"); // R3

  AST_STORE_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b01) |=> (rsp_perm_err == ($past(lk_perm) != 2'b10)))
    else $error("store permission mismatch"); // R4

endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_bound_err, rsp_perm_err;
  logic        priv_mode, tbl_wr_en;
  logic [2:0]  tbl_wr_idx;
  logic [31:0] tbl_wr_base;
  logic [28:0] tbl_wr_size;
  logic [1:0]  tbl_wr_perm;
  logic        wr_violation;
  logic [2:0]  tbl_rd_idx;
  logic [31:0] tbl_rd_base;
  logic [28:0] tbl_rd_size;
  logic [1:0]  tbl_rd_perm;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] m_base [8];
  logic [28:0] m_size [8];
  logic [1:0]  m_perm [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_bound_err(rsp_bound_err), .rsp_perm_err(rsp_perm_err),
    .priv_mode(priv_mode), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_base(tbl_wr_base), .tbl_wr_size(tbl_wr_size), .tbl_wr_perm(tbl_wr_perm),
    .wr_violation(wr_violation),
    .tbl_rd_idx(tbl_rd_idx), .tbl_rd_base(tbl_rd_base),
    .tbl_rd_size(tbl_rd_size), .tbl_rd_perm(tbl_rd_perm)
  );

  function automatic bit grants(input logic [1:0] p, input logic [1:0] k);
    case (p)
      2'b01:   return (k == 2'b00) || (k == 2'b11);
      2'b10:   return (k != 2'b10);
      2'b11:   return (k == 2'b10);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, check the registered result at the next one.
  task automatic step(input bit rv, input logic [31:0] va, input logic [1:0] kind,
                      input bit we, input bit pv, input logic [2:0] wi,
                      input logic [31:0] wb, input logic [28:0] ws, input logic [1:0] wp);
    logic [2:0]  seg;
    logic [28:0] off;
    bit          eb, ep;
    logic [31:0] epa;
    req_valid = rv; req_vaddr = va; req_kind = kind;
    tbl_wr_en = we; priv_mode = pv; tbl_wr_idx = wi;
    tbl_wr_base = wb; tbl_wr_size = ws; tbl_wr_perm = wp;
    seg = va[31:29];                       // R1 field split
    off = va[28:0];
    eb  = off > m_size[seg];
    ep  = !grants(m_perm[seg], kind);
    epa = (eb || ep) ? 32'h0 : m_base[seg] + {3'b000, off};
    @(posedge clk);
    if (we && pv) begin                    // R7: visible after the edge
      m_base[wi] = wb; m_size[wi] = ws; m_perm[wi] = wp;
    end
    @(negedge clk);
    chk("R5 rsp_valid", 64'(rsp_valid), 64'(rv));
    if (rv) begin
      chk("R1/R2/R6 rsp_paddr", 64'(rsp_paddr), 64'(epa));
      chk("R3 rsp_bound_err", 64'(rsp_bound_err), 64'(eb));
      chk("R4 rsp_perm_err", 64'(rsp_perm_err), 64'(ep));
    end else begin
      chk("R5 idle outputs", {31'b0, rsp_paddr, rsp_bound_err}, 64'(0));
      chk("R5 idle perm_err", 64'(rsp_perm_err), 64'(0));
    end
    chk("R8 wr_violation", 64'(wr_violation), 64'(we && !pv));
    req_valid = 1'b0; tbl_wr_en = 1'b0;
  endtask

  task automatic rd_all();
    for (int i = 0; i < 8; i++) begin
      tbl_rd_idx = 3'(i);
      #1;
      chk("R9 rd_base", 64'(tbl_rd_base), 64'(m_base[i]));
      chk("R9 rd_size", 64'(tbl_rd_size), 64'(m_size[i]));
      chk("R9 rd_perm", 64'(tbl_rd_perm), 64'(m_perm[i]));
    end
  endtask

  function automatic logic [31:0] va_of(input logic [2:0] s, input logic [28:0] o);
    return {s, o};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_size[i] = '0; m_perm[i] = 2'b00;
    end
    rst_n = 1'b0; req_valid = 0; req_vaddr = 0; req_kind = 0;
    priv_mode = 0; tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_base = 0;
    tbl_wr_size = 0; tbl_wr_perm = 0; tbl_rd_idx = 0;
    repeat (3) @(negedge clk);
    // Reset state: R5 and R9
    chk("R5 reset rsp_valid", 64'(rsp_valid), 64'(0));
    chk("R8 reset wr_violation", 64'(wr_violation), 64'(0));
    rd_all();
    rst_n = 1'b1;
    @(negedge clk);

    // Reset table grants nothing: R4 and R9
    step(1, va_of(3'd5, 29'd0), 2'b00, 0, 0, 0, 0, 0, 0);

    // Fill the table with privileged writes: R7
    for (int i = 0; i < 8; i++)
      step(0, 0, 0, 1, 1, 3'(i), $urandom, 29'($urandom), 2'(i));
    rd_all();

    // R3 boundary: offset equal to size and one past it
    step(0, 0, 0, 1, 1, 3'd2, 32'h1000_0000, 29'h100, 2'b10);
    step(1, va_of(3'd2, 29'h100), 2'b00, 0, 0, 0, 0, 0, 0);
    step(1, va_of(3'd2, 29'h101), 2'b00, 0, 0, 0, 0, 0, 0);
    // R2 wrap-around of the sum
    step(0, 0, 0, 1, 1, 3'd3, 32'hFFFF_FFF0, 29'h1FFF_FFFF, 2'b10);
    step(1, va_of(3'd3, 29'h20), 2'b01, 0, 0, 0, 0, 0, 0);
    // R4: every permission with every access kind
    for (int p = 0; p < 4; p++) begin
      step(0, 0, 0, 1, 1, 3'd4, 32'h0004_0000, 29'h1000, 2'(p));
      for (int k = 0; k < 4; k++)
        step(1, va_of(3'd4, 29'h10), 2'(k), 0, 0, 0, 0, 0, 0);
    end
    // R6: both errors at once
    step(0, 0, 0, 1, 1, 3'd6, 32'h0000_8000, 29'h10, 2'b00);
    step(1, va_of(3'd6, 29'h11), 2'b10, 0, 0, 0, 0, 0, 0);
    // R8: unprivileged write is ignored
    step(0, 0, 0, 1, 0, 3'd2, 32'hDEAD_0000, 29'h5, 2'b11);
    step(1, va_of(3'd2, 29'h100), 2'b00, 0, 0, 0, 0, 0, 0);
    rd_all();
    // R7: a request in the write cycle sees the old entry, then the new one
    step(1, va_of(3'd2, 29'h80), 2'b10, 1, 1, 3'd2, 32'h2000_0000, 29'h100, 2'b11);
    step(1, va_of(3'd2, 29'h80), 2'b10, 0, 0, 0, 0, 0, 0);

    // Constrained random
    for (int n = 0; n < 600; n++) begin
      logic [2:0]  s;
      logic [28:0] o;
      int          sel;
      s = 3'($urandom);
      sel = $urandom % 4;
      case (sel)
        0: o = m_size[s];
        1: o = m_size[s] + 29'd1;
        2: o = m_size[s] - 29'd1;
        default: o = 29'($urandom);
      endcase
      step(($urandom % 4) != 0, va_of(s, o), 2'($urandom),
           ($urandom % 3) == 0, ($urandom % 5) != 0, 3'($urandom),
           $urandom, 29'($urandom) >> ($urandom % 20), 2'($urandom));
    end
    rd_all();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule